// File: doc/BRIEF.md
# Programmable Square-Wave Clock Generator

This block derives a square-wave clock for an attached processor from a fixed system clock of `SYS_HZ` hertz. A compare counter, advanced by a selectable prescaler, flips the output level each time it reaches its compare value. One half-period is therefore (compare+1) x (prescale factor) system cycles.

A new target frequency is presented on `set_freq` together with a one-cycle `set_stb`. The block divides the system frequency by the request and halves the quotient, giving the half-period count. It then scales that count down through a short ladder of prescale steps until it fits the 16-bit compare register. If the request cannot be met, it signals an error and leaves the running clock untouched. Otherwise it halts and clears the counter, loads the new compare value and prescale select, and restarts. A second pass through the same sequential divider then produces the frequency actually generated, which is presented on `get_freq`.

Top module: `clkgen_top`

## Requirements
- R1: During and after reset `clk_out` starts low, `cmp_val` is 0, `presc_sel` is 1, `get_freq` is SYS_HZ/2 (truncated), and `clk_out` flips on every system cycle.
- R2: A strobe with `set_freq` equal to 0 or above SYS_HZ/2 gives `err_pulse` high for exactly the cycle after the strobe edge. `busy` stays low, and `cmp_val`, `presc_sel` and `get_freq` keep their values.
- R3: For an accepted request, the half-period count is floor(floor(SYS_HZ/set_freq)/2). While this count exceeds 65536, the prescale index (starting at 0) rises by one and the count is divided with truncation: by 8 when the index before the increment is 0 or 1, and by 4 otherwise.
- R4: If the index would have to pass 4, or the final count is 0, `err_pulse` is given once as `busy` falls, and the three setting outputs keep their earlier values.
- R5: On success `cmp_val` becomes count-1 and `presc_sel` becomes index+1. The `presc_sel` encoding is: 0 = halted, 1 = /1, 2 = /8, 3 = /64, 4 = /256, 5 = /1024.
- R6: On success `get_freq` becomes floor(SYS_HZ / ((cmp_val+1) x 2 x M)), where M is the divide factor selected by `presc_sel`.
- R7: In steady state `clk_out` changes level every (cmp_val+1) x M system cycles, and at no other time.
- R8: A new setting halts and clears the counter before loading it, so the first output edge after `busy` falls comes within one new half-period. With a compare value of 0 the counter is preset to all ones, so it matches on the next tick.
- R9: `busy` is high from the cycle after an accepted strobe until the new `get_freq` is valid. A strobe arriving while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (SYS_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_stb | input | 1 | One-cycle request strobe |
| set_freq | input | 32 | Requested output frequency in hertz |
| busy | output | 1 | Computation in progress; strobes ignored |
| err_pulse | output | 1 | One-cycle pulse for a rejected request |
| get_freq | output | 32 | Frequency produced by the present setting |
| cmp_val | output | 16 | Compare value in use |
| presc_sel | output | 3 | Prescale select in use (0 halted, 1..5 = /1,/8,/64,/256,/1024) |
| clk_out | output | 1 | Generated square wave |

## Verification
A request rejected for its range yields `err_pulse` in the first cycle after the strobe edge, with `busy` never raised. The bench samples on the falling edge right after that strobe edge. Every other request first raises `busy` one cycle after the strobe. Its outcome (the settings, `get_freq`, and any ladder-overflow `err_pulse`) is due in the cycle in which `busy` first reads low, so the bench polls `busy` on falling edges and checks all results in that cycle. Output timing is checked by counting falling edges between level changes. The first change after `busy` falls must come within one new half-period.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int IDX_W   = 3;
  localparam int SEL_W   = 3;
  localparam int MAX_IDX = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_CNT,
    ST_SCALE,
    ST_HALT,
    ST_LOAD,
    ST_DIV_GET
  } gen_state_t;

  // log2 of the prescale factor for a ladder index: 0,3,6,8,10
  function automatic logic [3:0] idx_shift(input logic [IDX_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i <= 2) return 4'(3 * i);
    else        return 4'(2 * i + 2);
  endfunction

  // log2 of the prescale factor for a select code (0 = halted)
  function automatic logic [3:0] sel_shift(input logic [SEL_W-1:0] sel);
    if (sel == '0) return 4'd0;
    else           return idx_shift(IDX_W'(sel - 1'b1));
  endfunction

endpackage

// File: rtl/clkgen_seqdiv.sv
module clkgen_seqdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dsr_q, dsr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [W:0]       shifted;
  logic [W:0]       trial;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dsr_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    dsr_d   = dsr_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    done_d  = 1'b0;
    if (start) begin
      rem_d = '0;
      quo_d = dividend;
      dsr_d = divisor;
      cnt_d = CNT_W'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      quo_d = {quo_q[W-2:0], ~trial[W]};
      rem_d = trial[W] ? shifted[W-1:0] : trial[W-1:0];
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dsr_q  <= dsr_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  AST_DIV_RUNS_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && !done_q)); // R3

endmodule

// File: rtl/clkgen_toggle_ctr.sv
module clkgen_toggle_ctr
  import clkgen_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int PCNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             load,
  input  logic [CMP_W-1:0] cmp_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic [CMP_W-1:0] cmp_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clk_out
);

  logic [CMP_W-1:0]  cmp_q, cmp_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [CMP_W-1:0]  cnt_q, cnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic              out_q, out_d;
  logic [PCNT_W:0]   mask_w;
  logic [PCNT_W-1:0] mask;
  logic              tick;
  logic [CMP_W-1:0]  cnt_nxt;

  always_comb begin
    mask_w  = ((PCNT_W + 1)'(1) << sel_shift(sel_q)) - 1'b1;
    mask    = mask_w[PCNT_W-1:0];
    tick    = (sel_q != '0) && (pcnt_q == mask);
    cnt_nxt = (cnt_q == cmp_q) ? '0 : cnt_q + 1'b1;
    cmp_d   = cmp_q;
    sel_d   = sel_q;
    cnt_d   = cnt_q;
    pcnt_d  = pcnt_q;
    out_d   = out_q;
    if (halt) begin
      sel_d  = '0;
      cnt_d  = '0;
      pcnt_d = '0;
    end else if (load) begin
      cmp_d  = cmp_in;
      sel_d  = sel_in;
      pcnt_d = '0;
      cnt_d  = (cmp_in == '0) ? '1 : '0;
    end else if (sel_q != '0) begin
      pcnt_d = tick ? '0 : pcnt_q + 1'b1;
      if (tick) begin
        cnt_d = cnt_nxt;
        if (cnt_nxt == cmp_q) out_d = ~out_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      sel_q  <= SEL_W'(1);
      cnt_q  <= '0;
      pcnt_q <= '0;
      out_q  <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
      out_q  <= out_d;
    end
  end

  assign cmp_o   = cmp_q;
  assign sel_o   = sel_q;
  assign clk_out = out_q;

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (sel_q == '0 && cnt_q == '0)); // R8

  AST_ZERO_CMP_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !halt && cmp_in == '0) |=> (&cnt_q)); // R8

  AST_EDGE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_q)); // R7

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int unsigned SYS_HZ = 200_000_000,
  parameter int          FREQ_W = 32,
  parameter int          CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic [FREQ_W-1:0] set_freq,
  output logic              busy,
  output logic              err_pulse,
  output logic [FREQ_W-1:0] get_freq,
  output logic [CMP_W-1:0]  cmp_val,
  output logic [SEL_W-1:0]  presc_sel,
  output logic              clk_out
);

  localparam int                PCNT_W  = int'(idx_shift(IDX_W'(MAX_IDX)));
  localparam logic [FREQ_W-1:0] SYS_VAL = FREQ_W'(SYS_HZ);
  localparam logic [FREQ_W-1:0] HALF_HZ = SYS_VAL >> 1;
  localparam logic [FREQ_W-1:0] LIMIT   = FREQ_W'(64'(1) << CMP_W);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  gen_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [FREQ_W-1:0] count_q, count_d;
  logic [FREQ_W-1:0] getf_q, getf_d;
  logic              err_q, err_d;

  logic              div_start, div_done;
  logic [FREQ_W-1:0] div_a, div_b, div_quo;
  logic              ctr_halt, ctr_load;
  logic              range_bad;

  always_comb begin
    range_bad = (set_freq == '0) || (set_freq > HALF_HZ);
    state_d   = state_q;
    idx_d     = idx_q;
    count_d   = count_q;
    getf_d    = getf_q;
    err_d     = 1'b0;
    div_start = 1'b0;
    div_a     = SYS_VAL;
    div_b     = set_freq;
    ctr_halt  = 1'b0;
    ctr_load  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (set_stb) begin
          if (range_bad) begin
            err_d = 1'b1;
          end else begin
            div_start = 1'b1;
            idx_d     = '0;
            state_d   = ST_DIV_CNT;
          end
        end
      end
      ST_DIV_CNT: begin
        if (div_done) begin
          count_d = div_quo >> 1;
          state_d = ST_SCALE;
        end
      end
      ST_SCALE: begin
        if (count_q > LIMIT) begin
          if (idx_q == IDX_W'(MAX_IDX)) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            count_d = (idx_q < IDX_W'(2)) ? (count_q >> 3) : (count_q >> 2);
          end
        end else if (count_q == '0) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_HALT;
        end
      end
      ST_HALT: begin
        ctr_halt = 1'b1;
        state_d  = ST_LOAD;
      end
      ST_LOAD: begin
        ctr_load  = 1'b1;
        div_start = 1'b1;
        div_a     = SYS_VAL >> (1 + int'(idx_shift(idx_q)));
        div_b     = count_q;
        state_d   = ST_DIV_GET;
      end
      ST_DIV_GET: begin
        if (div_done) begin
          getf_d  = div_quo;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      count_q <= '0;
      getf_q  <= HALF_HZ;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      count_q <= count_d;
      getf_q  <= getf_d;
      err_q   <= err_d;
    end
  end

  clkgen_seqdiv #(
    .W(FREQ_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_sync),
    .start    (div_start),
    .dividend (div_a),
    .divisor  (div_b),
    .done     (div_done),
    .quotient (div_quo)
  );

  clkgen_toggle_ctr #(
    .CMP_W  (CMP_W),
    .PCNT_W (PCNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync),
    .halt    (ctr_halt),
    .load    (ctr_load),
    .cmp_in  (CMP_W'(count_q - 1'b1)),
    .sel_in  (SEL_W'(idx_q) + 1'b1),
    .cmp_o   (cmp_val),
    .sel_o   (presc_sel),
    .clk_out (clk_out)
  );

  assign busy      = (state_q != ST_IDLE);
  assign err_pulse = err_q;
  assign get_freq  = getf_q;

  AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_sync)
    (!busy && set_stb && ((set_freq == '0) || (set_freq > HALF_HZ)))
      |=> (err_pulse && !busy)); // R2

  AST_KEEP_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_sync)
    err_pulse |-> ($stable(cmp_val) && $stable(presc_sel) && $stable(get_freq))); // R4

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync)
    presc_sel <= SEL_W'(MAX_IDX + 1)); // R5

  AST_BUSY_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy && set_stb) |=> !err_pulse || !busy); // R9

endmodule

// File: tb/test_clkgen_top.sv
module test_clkgen_top;

  localparam longint SYS = 200_000_000;
  localparam longint HALF = SYS / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        set_stb;
  logic [31:0] set_freq;
  logic        busy, err_pulse, clk_out;
  logic [31:0] get_freq;
  logic [15:0] cmp_val;
  logic [2:0]  presc_sel;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  clkgen_top #(.SYS_HZ(200_000_000)) i_clkgen_top (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_freq(set_freq),
    .busy(busy), .err_pulse(err_pulse), .get_freq(get_freq),
    .cmp_val(cmp_val), .presc_sel(presc_sel), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // requirement model: returns rejection flag and the expected settings
  task automatic model(input longint f, output bit rej, output longint cmp,
                       output longint sel, output longint gf);
    longint c;
    int idx;
    int sh;
    rej = 0; cmp = 0; sel = 0; gf = 0;
    c = (SYS / f) / 2;
    idx = 0;
    while (c > 65536 && !rej) begin
      if (idx == 4) rej = 1;
      else begin
        c = (idx < 2) ? c / 8 : c / 4;
        idx++;
      end
    end
    if (c == 0) rej = 1;
    if (!rej) begin
      cmp = c - 1;
      sel = idx + 1;
      sh = (idx <= 2) ? 3 * idx : 2 * idx + 2;
      gf = SYS / ((cmp + 1) * 2 * (longint'(1) << sh));
    end
  endtask

  task automatic request(input longint f);
    bit rej;
    longint ecmp, esel, egf, pcmp, psel, pgf;
    model(f, rej, ecmp, esel, egf);
    pcmp = cmp_val; psel = presc_sel; pgf = get_freq;
    @(negedge clk);
    set_stb = 1'b1;
    set_freq = 32'(f);
    @(negedge clk);
    set_stb = 1'b0;
    if (f == 0 || f > HALF) begin
      check(err_pulse === 1'b1, "R2 err", err_pulse, 1);
      check(busy === 1'b0, "R2 busy", busy, 0);
      check(cmp_val == pcmp && presc_sel == psel && get_freq == pgf, "R2 kept",
            cmp_val, pcmp);
      @(negedge clk);
      check(err_pulse === 1'b0, "R2 pulse width", err_pulse, 0);
    end else begin
      check(busy === 1'b1, "R9 busy raised", busy, 1);
      while (busy) @(negedge clk);
      if (rej) begin
        check(err_pulse === 1'b1, "R4 err", err_pulse, 1);
        check(cmp_val == pcmp && presc_sel == psel && get_freq == pgf, "R4 kept",
              cmp_val, pcmp);
      end else begin
        check(err_pulse === 1'b0, "R3 no err", err_pulse, 0);
        check(cmp_val == ecmp, "R3 cmp", cmp_val, ecmp);
        check(presc_sel == esel, "R5 sel", presc_sel, esel);
        check(get_freq == egf, "R6 get_freq", get_freq, egf);
      end
    end
  endtask

  // count falling edges between two output changes
  task automatic measure(output int len);
    logic lv;
    int n;
    lv = clk_out;
    n = 0;
    while (clk_out == lv && n < 5000) begin @(negedge clk); n++; end
    lv = clk_out;
    n = 0;
    while (clk_out == lv && n < 5000) begin @(negedge clk); n++; end
    len = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len;
    logic a;
    rst_n = 1'b0;
    set_stb = 1'b0;
    set_freq = '0;
    repeat (4) @(negedge clk);
    check(clk_out === 1'b0, "R1 low in reset", clk_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmp_val == 0, "R1 cmp", cmp_val, 0);
    check(presc_sel == 1, "R1 sel", presc_sel, 1);
    check(get_freq == HALF, "R1 get_freq", get_freq, HALF);
    check(busy === 1'b0, "R1 idle", busy, 0);
    for (int i = 0; i < 6; i++) begin
      a = clk_out;
      @(negedge clk);
      check(clk_out === ~a, "R1 toggles every cycle", clk_out, ~a);
    end

    // range rejects
    request(0);
    request(HALF + 1);
    request(64'hFFFF_FFFF);
    // ladder overflow rejects and the smallest accepted requests
    for (int f = 1; f <= 24; f++) request(f);
    // powers of two across the whole range
    for (int k = 0; k < 32; k++) request(longint'(1) << k);
    // around the first ladder step
    for (int f = 1518; f <= 1532; f++) request(f);
    // spread values
    for (int i = 1; i <= 40; i++) request(longint'(7919) * i * i + 3);
    request(HALF);
    request(HALF - 1);

    // output period, no prescale
    request(100_000);
    measure(len);
    check(len == 1000, "R7 period cmp 999", len, 1000);
    // restart from a slow setting to a fast one
    request(25_000_000);
    len = 0;
    a = clk_out;
    while (clk_out == a && len < 5000) begin @(negedge clk); len++; end
    check(len <= 4, "R8 first edge after restart", len, 4);
    measure(len);
    check(len == 4, "R7 period cmp 3", len, 4);
    // compare value zero
    request(HALF);
    measure(len);
    check(len == 1, "R8 cmp 0 toggles each tick", len, 1);

    // strobe while busy is ignored
    @(negedge clk);
    set_stb = 1'b1;
    set_freq = 32'd25_000_000;
    @(negedge clk);
    set_stb = 1'b1;
    set_freq = 32'd1000;
    @(negedge clk);
    set_stb = 1'b0;
    check(busy === 1'b1, "R9 busy", busy, 1);
    while (busy) @(negedge clk);
    check(cmp_val == 3, "R9 second strobe ignored cmp", cmp_val, 3);
    check(presc_sel == 1, "R9 second strobe ignored sel", presc_sel, 1);
    check(get_freq == 25_000_000, "R9 get_freq", get_freq, 25_000_000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule